// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns an addressing-mode code into the 16-bit address of an instruction's operand. The caller gives it a mode, the program counter (already pointing at the first operand byte) and the two 8-bit index registers X and Y, then pulses `start`. The unit reads the operand bytes, and for the pointer modes the pointer bytes, from a synchronous byte memory that returns data one cycle after the request. When the address is ready it pulses `done` and holds the address on `eaAddr`.

Page-zero arithmetic and full-range arithmetic are kept apart. A zero-page index sum and a page-zero pointer fetch wrap inside addresses 0x0000 to 0x00FF. Absolute index sums and the post-indexed pointer sum wrap across the whole 16-bit space. A mode code with no defined addressing gives an error pulse instead of an address. Reading the operand value, and any extra cycle when an index sum crosses a page, belong to other logic.

Top module: `opnd_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released with no request, `done`, `err` and `memRd` are low and `eaAddr` is zero.
- R2: Mode code 0 (immediate) returns `pc` unchanged, makes no memory read, and pulses `done` one cycle after the accepting clock edge.
- R3: Mode code 1 (zero page) returns the byte at `pc` zero-extended to 16 bits, after exactly one read, with `done` three cycles after the accepting edge.
- R4: Mode codes 2 (zero page + X) and 3 (zero page + Y) return (byte at `pc` + index) modulo 256, so bits 15..8 of the result are zero. Each uses one read.
- R5: Mode code 4 (absolute) returns a little-endian word whose low byte is at `pc` and high byte at `pc`+1, where `pc`+1 wraps modulo 65536. It uses two reads and `done` comes four cycles after the accepting edge.
- R6: Mode codes 5 (absolute + X) and 6 (absolute + Y) add the zero-extended index to the absolute word modulo 65536.
- R7: Mode code 7 (pre-indexed pointer) forms p = (byte at `pc` + X) modulo 256 and returns the word with its low byte at p and its high byte at (p+1) modulo 256. It uses three reads and `done` comes five cycles after the accepting edge.
- R8: Mode code 8 (post-indexed pointer) takes p = byte at `pc`. It reads the word at p and (p+1) modulo 256 and returns that word plus Y, modulo 65536.
- R9: Mode codes 9 to 15 are unsupported. For them `err` and `done` pulse together one cycle after the accepting edge with `eaAddr` zero, no read is made, and `err` never rises for a supported code.
- R10: `done` is a single-cycle pulse for each accepted request, and `err` is never high without `done`.
- R11: A `start` that arrives while a request is in progress is ignored: it yields no extra `done`, no change to the result, and no read outside a request.
- R12: Each read is one cycle with `memRd` high and `memAddr` valid, and the data is taken on `memData` in the next cycle. The read count is 0 for immediate or unsupported codes, 1 for the zero-page forms, 2 for the absolute forms and 3 for the pointer forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| mode | input | 4 | Addressing-mode code |
| pc | input | 16 | Address of the first operand byte |
| xIdx | input | 8 | X index register |
| yIdx | input | 8 | Y index register |
| memAddr | output | 16 | Memory read address |
| memRd | output | 1 | Memory read strobe |
| memData | input | 8 | Read data, valid the cycle after `memRd` |
| eaAddr | output | 16 | Computed operand address, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported-mode pulse, coincident with `done` |

## Verification
The bound checker watches every cycle for rules that need no knowledge of memory contents. It checks that the number of reads matches the latched mode at each `done`, that immediate results equal the latched `pc`, and that zero-page results stay in page zero. It also checks that error pulses carry a zero address and come only for unsupported codes, and that no read happens while idle. Only the bench scenarios can show the actual address values. These depend on the bytes the memory returns, and they include the wrap at page zero's top and at the end of the 16-bit space, the exact completion latency per mode, and a second `start` being dropped mid-request.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

  typedef enum logic [3:0] {
    AM_IMM  = 4'd0,
    AM_ZP   = 4'd1,
    AM_ZPX  = 4'd2,
    AM_ZPY  = 4'd3,
    AM_ABS  = 4'd4,
    AM_ABSX = 4'd5,
    AM_ABSY = 4'd6,
    AM_INDX = 4'd7,
    AM_INDY = 4'd8
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP,
    ST_B1,
    ST_B2,
    ST_B3
  } state_e;

  // read address source
  typedef enum logic [1:0] {
    AS_PC,
    AS_PC1,
    AS_PTR,
    AS_PTR1
  } asel_e;

  // result source
  typedef enum logic [1:0] {
    RS_PC,
    RS_ZP,
    RS_WIDE,
    RS_ZERO
  } rsel_e;

  typedef struct packed {
    logic  load;
    logic  rd;
    asel_e asel;
    logic  capLo;
    logic  capPtr;
    logic  idxEn;
    logic  idxY;
    logic  fin;
    rsel_e rsel;
    logic  err;
  } strobe_t;

endpackage

// File: rtl/eagen_ctrl.sv
module eagen_ctrl
  import eagen_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  output strobe_t           stb,
  output logic              busy
);

  state_e            state, stateNext;
  logic [MODE_W-1:0] modeQ;

  function automatic logic usesY(input logic [MODE_W-1:0] m);
    return (m == AM_ZPY) || (m == AM_ABSY) || (m == AM_INDY);
  endfunction

  function automatic logic isZpForm(input logic [MODE_W-1:0] m);
    return (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY);
  endfunction

  function automatic logic isAbsForm(input logic [MODE_W-1:0] m);
    return (m == AM_ABS) || (m == AM_ABSX) || (m == AM_ABSY);
  endfunction

  function automatic logic needsMem(input logic [MODE_W-1:0] m);
    return isZpForm(m) || isAbsForm(m) || (m == AM_INDX) || (m == AM_INDY);
  endfunction

  always_comb begin
    stb       = '0;
    stb.asel  = AS_PC;
    stb.rsel  = RS_PC;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (mode == AM_IMM) begin
            stb.fin  = 1'b1;
            stb.rsel = RS_PC;
          end else if (needsMem(mode)) begin
            stb.load  = 1'b1;
            stateNext = ST_OP;
          end else begin
            stb.fin  = 1'b1;
            stb.rsel = RS_ZERO;
            stb.err  = 1'b1;
          end
        end
      end
      ST_OP: begin
        stb.rd    = 1'b1;
        stb.asel  = AS_PC;
        stateNext = ST_B1;
      end
      ST_B1: begin
        stb.idxY = usesY(modeQ);
        if (isZpForm(modeQ)) begin
          stb.fin   = 1'b1;
          stb.rsel  = RS_ZP;
          stb.idxEn = (modeQ != AM_ZP);
          stateNext = ST_IDLE;
        end else if (isAbsForm(modeQ)) begin
          stb.rd    = 1'b1;
          stb.asel  = AS_PC1;
          stb.capLo = 1'b1;
          stateNext = ST_B2;
        end else begin
          stb.rd     = 1'b1;
          stb.asel   = AS_PTR;
          stb.capPtr = 1'b1;
          stb.idxEn  = (modeQ == AM_INDX);
          stateNext  = ST_B2;
        end
      end
      ST_B2: begin
        stb.idxY = usesY(modeQ);
        if (isAbsForm(modeQ)) begin
          stb.fin   = 1'b1;
          stb.rsel  = RS_WIDE;
          stb.idxEn = (modeQ != AM_ABS);
          stateNext = ST_IDLE;
        end else begin
          stb.rd    = 1'b1;
          stb.asel  = AS_PTR1;
          stb.capLo = 1'b1;
          stateNext = ST_B3;
        end
      end
      ST_B3: begin
        stb.fin   = 1'b1;
        stb.rsel  = RS_WIDE;
        stb.idxY  = 1'b1;
        stb.idxEn = (modeQ == AM_INDY);
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeQ <= '0;
    end else begin
      state <= stateNext;
      if (stb.load) modeQ <= mode;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/eagen_dp.sv
module eagen_dp
  import eagen_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] xIdx,
  input  logic [DATA_W-1:0] yIdx,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic [ADDR_W-1:0] eaAddr,
  output logic              done,
  output logic              err
);

  logic [ADDR_W-1:0] pcQ, addrQ, result, wideSum;
  logic [DATA_W-1:0] xQ, yQ, loQ, ptrQ, idx, zpSum;
  logic              doneQ, errQ;

  assign idx     = stb.idxEn ? (stb.idxY ? yQ : xQ) : '0;
  assign zpSum   = memData + idx;
  assign wideSum = {memData, loQ} + {{DATA_W{1'b0}}, idx};

  always_comb begin
    case (stb.asel)
      AS_PC:   memAddr = pcQ;
      AS_PC1:  memAddr = pcQ + ADDR_W'(1);
      AS_PTR:  memAddr = {{DATA_W{1'b0}}, zpSum};
      AS_PTR1: memAddr = {{DATA_W{1'b0}}, ptrQ + DATA_W'(1)};
      default: memAddr = pcQ;
    endcase
  end

  assign memRd = stb.rd;

  always_comb begin
    case (stb.rsel)
      RS_PC:   result = pc;
      RS_ZP:   result = {{DATA_W{1'b0}}, zpSum};
      RS_WIDE: result = wideSum;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= '0;
      xQ    <= '0;
      yQ    <= '0;
      loQ   <= '0;
      ptrQ  <= '0;
      addrQ <= '0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      if (stb.load) begin
        pcQ <= pc;
        xQ  <= xIdx;
        yQ  <= yIdx;
      end
      if (stb.capLo)  loQ  <= memData;
      if (stb.capPtr) ptrQ <= zpSum;
      if (stb.fin)    addrQ <= result;
      doneQ <= stb.fin;
      errQ  <= stb.err;
    end
  end

  assign eaAddr = addrQ;
  assign done   = doneQ;
  assign err    = errQ;

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import eagen_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 4,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] xIdx,
  input  logic [DATA_W-1:0] yIdx,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] eaAddr,
  output logic              done,
  output logic              err
);

  strobe_t ctrlStb;
  logic    ctrlBusy;

  eagen_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .mode (mode),
    .stb  (ctrlStb),
    .busy (ctrlBusy)
  );

  eagen_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (ctrlStb),
    .pc     (pc),
    .xIdx   (xIdx),
    .yIdx   (yIdx),
    .memData(memData),
    .memAddr(memAddr),
    .memRd  (memRd),
    .eaAddr (eaAddr),
    .done   (done),
    .err    (err)
  );

endmodule

// File: rtl/eagen_chk.sv
module eagen_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [3:0]  mode,
  input logic [15:0] pc,
  input logic        memRd,
  input logic [15:0] eaAddr,
  input logic        done,
  input logic        err,
  input logic        busy
);

  logic [3:0]  mQ;
  logic [15:0] pQ;
  logic [1:0]  rdCnt;

  function automatic logic [1:0] expReads(input logic [3:0] m);
    if (m >= 4'd1 && m <= 4'd3) return 2'd1;
    if (m >= 4'd4 && m <= 4'd6) return 2'd2;
    if (m == 4'd7 || m == 4'd8) return 2'd3;
    return 2'd0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mQ    <= '0;
      pQ    <= '0;
      rdCnt <= '0;
    end else if (start && !busy) begin
      mQ    <= mode;
      pQ    <= pc;
      rdCnt <= '0;
    end else if (memRd) begin
      rdCnt <= rdCnt + 2'd1;
    end
  end

  p_read_count_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rdCnt == expReads(mQ)));

  p_imm_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && mQ == 4'd0) |-> (eaAddr == pQ));

  p_zp_page_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !err && mQ >= 4'd1 && mQ <= 4'd3) |-> (eaAddr[15:8] == 8'h00));

  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (eaAddr == 16'h0000));

  p_err_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (err == (mQ > 4'd8)));

  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  p_idle_no_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memRd);

endmodule

bind opnd_addr_gen eagen_chk u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .mode  (mode),
  .pc    (pc),
  .memRd (memRd),
  .eaAddr(eaAddr),
  .done  (done),
  .err   (err),
  .busy  (ctrlBusy)
);

// File: tb/opnd_addr_gen_test.sv
`timescale 1ns/1ps
module opnd_addr_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  xIdx = '0;
  logic [7:0]  yIdx = '0;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memData = '0;
  logic [15:0] eaAddr;
  logic        done;
  logic        err;

  int checks = 0;
  int errors = 0;
  int rdTotal = 0;
  bit finished = 0;

  logic [15:0] ovAddr [0:7];
  logic [7:0]  ovData [0:7];
  logic        ovVal  [0:7];

  always #2 clk = ~clk;

  opnd_addr_gen uut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .pc(pc),
    .xIdx(xIdx), .yIdx(yIdx), .memAddr(memAddr), .memRd(memRd),
    .memData(memData), .eaAddr(eaAddr), .done(done), .err(err)
  );

  function automatic logic [7:0] memAt(input logic [15:0] a);
    logic [7:0] v;
    v = a[7:0] ^ a[15:8] ^ 8'hA5;
    for (int i = 0; i < 8; i++)
      if (ovVal[i] && ovAddr[i] == a) v = ovData[i];
    return v;
  endfunction

  // synchronous memory with one-cycle read latency
  always @(posedge clk) begin
    if (memRd) begin
      memData <= memAt(memAddr);
      rdTotal <= rdTotal + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 8; i++) ovVal[i] = 1'b0;
  endtask

  task automatic setMem(input int i, input logic [15:0] a, input logic [7:0] d);
    ovAddr[i] = a;
    ovData[i] = d;
    ovVal[i]  = 1'b1;
  endtask

  // issue one request and check address, error, reads, latency and pulse width
  task automatic runOp(input logic [3:0] m, input logic [15:0] p,
                       input logic [7:0] xv, input logic [7:0] yv, input string req);
    logic [7:0]  b, ptr, lo, hi, zs;
    logic [15:0] expA;
    logic        expE;
    int          expR, expL, lat, r0;
    b = memAt(p);
    expE = 1'b0;
    case (m)
      4'd0: begin expA = p; expR = 0; expL = 1; end
      4'd1: begin expA = {8'h00, b}; expR = 1; expL = 3; end
      4'd2: begin zs = b + xv; expA = {8'h00, zs}; expR = 1; expL = 3; end
      4'd3: begin zs = b + yv; expA = {8'h00, zs}; expR = 1; expL = 3; end
      4'd4, 4'd5, 4'd6: begin
        expA = {memAt(p + 16'd1), b};
        if (m == 4'd5) expA = expA + {8'h00, xv};
        if (m == 4'd6) expA = expA + {8'h00, yv};
        expR = 2; expL = 4;
      end
      4'd7, 4'd8: begin
        ptr = (m == 4'd7) ? b + xv : b;
        lo  = memAt({8'h00, ptr});
        ptr = ptr + 8'd1;
        hi  = memAt({8'h00, ptr});
        expA = {hi, lo};
        if (m == 4'd8) expA = expA + {8'h00, yv};
        expR = 3; expL = 5;
      end
      default: begin expA = 16'h0000; expE = 1'b1; expR = 0; expL = 1; end
    endcase
    @(negedge clk);
    mode = m; pc = p; xIdx = xv; yIdx = yv; start = 1'b1;
    r0 = rdTotal;
    lat = 0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      if (done) break;
    end
    check(done === 1'b1, req, "done seen", {31'd0, done}, 32'd1);
    check(eaAddr === expA, req, "address", {16'd0, eaAddr}, {16'd0, expA});
    check(err === expE, req, "error flag", {31'd0, err}, {31'd0, expE});
    check(lat == expL, req, "latency", lat, expL);
    check((rdTotal - r0) == expR, req, "read count R12", rdTotal - r0, expR);
    @(negedge clk);
    check(done === 1'b0 && err === 1'b0, "R10", "pulse ends", {30'd0, done, err}, 32'd0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(done === 1'b0 && err === 1'b0 && memRd === 1'b0, "R1", "flags in reset",
          {29'd0, done, err, memRd}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(eaAddr === 16'h0000 && done === 1'b0, "R1", "idle after reset",
          {15'd0, done, eaAddr}, 32'd0);
  endtask

  // R11: a second start during a request is dropped
  task automatic testBusyStart();
    logic [15:0] expA;
    int dones;
    clearMem();
    setMem(0, 16'h3000, 8'h21);
    setMem(1, 16'h3001, 8'h43);
    expA = 16'h4321;
    @(negedge clk);
    mode = 4'd4; pc = 16'h3000; start = 1'b1;
    @(negedge clk);
    mode = 4'd0; pc = 16'hBEEF;
    dones = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (done) begin
        dones++;
        check(eaAddr === expA, "R11", "result of first request",
              {16'd0, eaAddr}, {16'd0, expA});
      end
    end
    check(dones == 1, "R11", "single done", dones, 1);
  endtask

  initial begin
    clearMem();
    testReset();
    // R2
    runOp(4'd0, 16'h1234, 8'h11, 8'h22, "R2");
    // R3
    clearMem(); setMem(0, 16'h0400, 8'h80);
    runOp(4'd1, 16'h0400, 8'h00, 8'h00, "R3");
    // R4 with page-zero wrap
    clearMem(); setMem(0, 16'h0500, 8'hF0);
    runOp(4'd2, 16'h0500, 8'h20, 8'h00, "R4");
    runOp(4'd3, 16'h0500, 8'h00, 8'h0F, "R4");
    // R5 normal and pc+1 wrapping past the top
    clearMem(); setMem(0, 16'h0600, 8'h34); setMem(1, 16'h0601, 8'h12);
    runOp(4'd4, 16'h0600, 8'h00, 8'h00, "R5");
    clearMem(); setMem(0, 16'hFFFF, 8'hCD); setMem(1, 16'h0000, 8'hAB);
    runOp(4'd4, 16'hFFFF, 8'h00, 8'h00, "R5");
    // R6 with full 16-bit wrap
    clearMem(); setMem(0, 16'h0700, 8'hF0); setMem(1, 16'h0701, 8'hFF);
    runOp(4'd5, 16'h0700, 8'h20, 8'h00, "R6");
    runOp(4'd6, 16'h0700, 8'h00, 8'h05, "R6");
    // R7 pointer wraps to 0x00, then pointer at 0xFF with high byte from 0x00
    clearMem(); setMem(0, 16'h0800, 8'h10); setMem(1, 16'h0000, 8'h78);
    setMem(2, 16'h0001, 8'h56);
    runOp(4'd7, 16'h0800, 8'hF0, 8'h00, "R7");
    clearMem(); setMem(0, 16'h0810, 8'hFE); setMem(1, 16'h00FF, 8'h9A);
    setMem(2, 16'h0000, 8'hBC); setMem(3, 16'h0100, 8'h11);
    runOp(4'd7, 16'h0810, 8'h01, 8'h00, "R7");
    // R8 pointer at 0xFF, sum wraps 16 bits
    clearMem(); setMem(0, 16'h0900, 8'hFF); setMem(1, 16'h00FF, 8'hFE);
    setMem(2, 16'h0000, 8'hFF); setMem(3, 16'h0100, 8'h22);
    runOp(4'd8, 16'h0900, 8'h00, 8'h04, "R8");
    clearMem(); setMem(0, 16'h0A00, 8'h40); setMem(1, 16'h0040, 8'h00);
    setMem(2, 16'h0041, 8'h20);
    runOp(4'd8, 16'h0A00, 8'h00, 8'h10, "R8");
    // R9 unsupported codes
    runOp(4'd9, 16'h1111, 8'h00, 8'h00, "R9");
    runOp(4'd15, 16'h2222, 8'h00, 8'h00, "R9");
    // R10 back-to-back immediate requests still give clean pulses
    runOp(4'd0, 16'hFFFF, 8'h00, 8'h00, "R10");
    testBusyStart();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule